// File: doc/BRIEF.md
# Transmit Byte Buffer with Rewind and Threshold Status

This block is a byte-wide first-in first-out store placed between a serial write port and a packet framer. The write side pushes bytes; the framer pops them in order and receives each byte on a registered output one cycle after it asks. The usable capacity is chosen at run time between a shallow setting of 32 bytes and a deep setting of 64 bytes. The deep setting is the full size of the storage.

Two commands act on the whole buffer. A clear command empties it and marks the current write position as the start of a new packet. A rewind command moves the read side back to that start, so a packet that has already been sent can be sent again without writing it a second time. The block keeps sticky flags for a write into a full buffer and a read from an empty one. It drives three status outputs: not empty, fill at or above a programmable threshold, and full. Each output can be set active-high or active-low.

Top module: `txbuf_fifo`

## Requirements
- R1: After reset the fill count is 0, the shallow (32-byte) capacity is selected (`deep_mode`=0), both sticky flags are 0 and `rd_data` is 0.
- R2: Bytes are read out in the order they were written. A read accepted in one cycle presents its byte on `rd_data` after the next clock edge. `rd_data` holds its value when no read is made. `fill` counts the bytes that are stored and not yet read.
- R3: A write while `fill` equals the capacity is dropped, leaves `fill` unchanged and sets the sticky `ovf` flag.
- R4: A read while `fill` is 0 makes `rd_data` 0 and sets the sticky `udf` flag.
- R5: `clr` has the highest priority. It empties the buffer and clears `ovf` and `udf`. A write or read in the same cycle is ignored.
- R6: `rewind` (when `clr` is low) moves the read position back to the first byte written since the last clear, a resize or reset. `fill` then equals the number of bytes written since that point, and those bytes are read again in their original order. A write or read in the same cycle is ignored.
- R7: `rewind` is ignored, and leaves `fill` unchanged, once the number of bytes accepted since the last clear is greater than the capacity, because the first byte has then been overwritten.
- R8: `depth_sel` (0 = 32 bytes, 1 = 64 bytes) is applied in a cycle with `fill`=0 and no write, read, clear or rewind. Applying it empties the buffer. At any other time the request is ignored, and it takes effect in a later qualifying cycle if it is still held.
- R9: The full status is set exactly when `fill` equals the selected capacity. The not-empty status is set exactly when `fill` is greater than 0. `fill` never exceeds the capacity.
- R10: The threshold status is set exactly when `fill` >= `thresh`.
- R11: With `irq_pol`=0 the status outputs are active-high. With `irq_pol`=1 each of `irq_nempty`, `irq_thr` and `irq_full` is the inverse of its status.
- R12: A write and a read in the same cycle are each judged on the fill at the start of the cycle. Below capacity and above zero, both are accepted and `fill` is unchanged. At capacity, the read is accepted and the write is dropped with `ovf` set. At zero, the write is accepted and the read returns 0 with `udf` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one byte |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read one byte |
| rd_data | output | 8 | Byte read, valid the cycle after the read |
| clr | input | 1 | Empty the buffer and clear sticky flags |
| rewind | input | 1 | Move the read side back to the packet start |
| depth_sel | input | 1 | Requested capacity: 0 = 32, 1 = 64 |
| thresh | input | 7 | Threshold for the threshold status |
| irq_pol | input | 1 | 1 inverts the three status outputs |
| fill | output | 7 | Bytes stored and not yet read |
| deep_mode | output | 1 | Capacity in force: 0 = 32, 1 = 64 |
| ovf | output | 1 | Sticky: a write was dropped |
| udf | output | 1 | Sticky: a read found the buffer empty |
| irq_nempty | output | 1 | Not-empty status after polarity |
| irq_thr | output | 1 | Threshold status after polarity |
| irq_full | output | 1 | Full status after polarity |

## Verification
The properties assume that all inputs are stable around the rising edge and are known once reset is released. They also assume that `clr` and `rewind` are the only commands that can override a write or a read in the same cycle. The stimulus drives every input just after the falling edge and holds `depth_sel` equal to the capacity in force, except in the one sequence that tests a resize request made while the buffer holds data. Outside reset, nothing is driven to an unknown value. Rewind is tested both inside and beyond the capacity window, so the overwrite rule of R7 is reached through ordinary writes only.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

    localparam int BYTE_W      = 8;
    localparam int DEEP_BYTES  = 64;
    localparam int SHALLOW_BYTES = 32;

    // Whole-buffer command in force this cycle, highest priority first
    typedef enum logic [1:0] {
        CMD_DATA    = 2'd0,
        CMD_CLEAR   = 2'd1,
        CMD_RESTORE = 2'd2,
        CMD_RESIZE  = 2'd3
    } fifo_cmd_e;

    function automatic fifo_cmd_e pick_cmd(input logic clr_i,
                                           input logic rewind_i,
                                           input logic resize_i);
        fifo_cmd_e c;
        if (clr_i)         c = CMD_CLEAR;
        else if (rewind_i) c = CMD_RESTORE;
        else if (resize_i) c = CMD_RESIZE;
        else               c = CMD_DATA;
        return c;
    endfunction

    // Status vector positions
    localparam int FLAG_NEMPTY = 0;
    localparam int FLAG_THR    = 1;
    localparam int FLAG_FULL   = 2;
    localparam int NUM_FLAGS   = 3;

endpackage

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
    import txbuf_pkg::*;
#(
    parameter  int DEEP    = DEEP_BYTES,
    parameter  int SHALLOW = SHALLOW_BYTES,
    localparam int CNT_W   = $clog2(DEEP) + 1,
    localparam int ADDR_W  = $clog2(DEEP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              clr,
    input  logic              rewind,
    input  logic              depth_sel,
    output logic              push_ok,
    output logic              pop_ok,
    output logic              pop_zero,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W-1:0] raddr,
    output logic [CNT_W-1:0]  fill,
    output logic [CNT_W-1:0]  cap,
    output logic              deep_mode,
    output logic              ovf,
    output logic              udf
);

    typedef struct packed {
        logic [CNT_W-1:0] wptr;
        logic [CNT_W-1:0] rptr;
        logic [CNT_W-1:0] fill;
        logic             deep;
        logic             lost;
        logic             ovf;
        logic             udf;
    } ctl_t;

    ctl_t      st_d, st_q;
    fifo_cmd_e cmd;
    logic [CNT_W-1:0] mask;
    logic      resize_req;

    always_comb begin
        cap  = st_q.deep ? CNT_W'(DEEP) : CNT_W'(SHALLOW);
        mask = cap - CNT_W'(1);
        resize_req = (depth_sel != st_q.deep) && (st_q.fill == '0)
                     && !wr_en && !rd_en;
        cmd = pick_cmd(clr, rewind, resize_req);

        st_d     = st_q;
        push_ok  = 1'b0;
        pop_ok   = 1'b0;
        pop_zero = 1'b0;

        case (cmd)
            CMD_CLEAR: begin
                st_d.wptr = '0;
                st_d.rptr = '0;
                st_d.fill = '0;
                st_d.lost = 1'b0;
                st_d.ovf  = 1'b0;
                st_d.udf  = 1'b0;
            end
            CMD_RESTORE: begin
                if (!st_q.lost) begin
                    st_d.rptr = '0;
                    st_d.fill = st_q.wptr;
                end
            end
            CMD_RESIZE: begin
                st_d.deep = depth_sel;
                st_d.wptr = '0;
                st_d.rptr = '0;
                st_d.fill = '0;
                st_d.lost = 1'b0;
            end
            default: begin
                push_ok  = wr_en && (st_q.fill < cap);
                pop_ok   = rd_en && (st_q.fill != '0);
                pop_zero = rd_en && (st_q.fill == '0);
                if (wr_en && !push_ok) st_d.ovf = 1'b1;
                if (pop_zero)          st_d.udf = 1'b1;
                if (push_ok) begin
                    st_d.wptr = st_q.wptr + CNT_W'(1);
                    if (st_q.wptr == cap) st_d.lost = 1'b1;
                end
                if (pop_ok) st_d.rptr = st_q.rptr + CNT_W'(1);
                case ({push_ok, pop_ok})
                    2'b10:   st_d.fill = st_q.fill + CNT_W'(1);
                    2'b01:   st_d.fill = st_q.fill - CNT_W'(1);
                    default: st_d.fill = st_q.fill;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr     = ADDR_W'(st_q.wptr & mask);
    assign raddr     = ADDR_W'(st_q.rptr & mask);
    assign fill      = st_q.fill;
    assign deep_mode = st_q.deep;
    assign ovf       = st_q.ovf;
    assign udf       = st_q.udf;

endmodule

// File: rtl/txbuf_mem.sv
module txbuf_mem
    import txbuf_pkg::*;
#(
    parameter  int DEPTH  = DEEP_BYTES,
    parameter  int DATA_W = BYTE_W,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic              rzero,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_comb begin
        rd_d = rd_q;
        if (re)         rd_d = store[raddr];
        else if (rzero) rd_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q;

endmodule

// File: rtl/txbuf_irq.sv
module txbuf_irq
    import txbuf_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0]     fill,
    input  logic [CNT_W-1:0]     cap,
    input  logic [CNT_W-1:0]     thresh,
    input  logic                 irq_pol,
    output logic [NUM_FLAGS-1:0] irq_o
);

    logic [NUM_FLAGS-1:0] stat;

    always_comb begin
        stat              = '0;
        stat[FLAG_NEMPTY] = (fill != '0);
        stat[FLAG_THR]    = (fill >= thresh);
        stat[FLAG_FULL]   = (fill == cap);
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_pol
        assign irq_o[i] = stat[i] ^ irq_pol;
    end

endmodule

// File: rtl/txbuf_fifo.sv
module txbuf_fifo
    import txbuf_pkg::*;
#(
    parameter  int DEEP    = DEEP_BYTES,
    parameter  int SHALLOW = SHALLOW_BYTES,
    parameter  int DATA_W  = BYTE_W,
    localparam int CNT_W   = $clog2(DEEP) + 1,
    localparam int ADDR_W  = $clog2(DEEP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              clr,
    input  logic              rewind,
    input  logic              depth_sel,
    input  logic [CNT_W-1:0]  thresh,
    input  logic              irq_pol,
    output logic [CNT_W-1:0]  fill,
    output logic              deep_mode,
    output logic              ovf,
    output logic              udf,
    output logic              irq_nempty,
    output logic              irq_thr,
    output logic              irq_full
);

    logic              push_ok, pop_ok, pop_zero;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [CNT_W-1:0]  cap;
    logic [NUM_FLAGS-1:0] irq_vec;

    txbuf_ctrl #(.DEEP(DEEP), .SHALLOW(SHALLOW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .clr       (clr),
        .rewind    (rewind),
        .depth_sel (depth_sel),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .pop_zero  (pop_zero),
        .waddr     (waddr),
        .raddr     (raddr),
        .fill      (fill),
        .cap       (cap),
        .deep_mode (deep_mode),
        .ovf       (ovf),
        .udf       (udf)
    );

    txbuf_mem #(.DEPTH(DEEP), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (push_ok),
        .waddr (waddr),
        .wdata (wr_data),
        .re    (pop_ok),
        .rzero (pop_zero),
        .raddr (raddr),
        .rdata (rd_data)
    );

    txbuf_irq #(.CNT_W(CNT_W)) u_irq (
        .fill    (fill),
        .cap     (cap),
        .thresh  (thresh),
        .irq_pol (irq_pol),
        .irq_o   (irq_vec)
    );

    assign irq_nempty = irq_vec[FLAG_NEMPTY];
    assign irq_thr    = irq_vec[FLAG_THR];
    assign irq_full   = irq_vec[FLAG_FULL];

endmodule

// File: rtl/txbuf_fifo_chk.sv
module txbuf_fifo_chk #(
    parameter  int DEEP    = 64,
    parameter  int SHALLOW = 32,
    parameter  int DATA_W  = 8,
    localparam int CNT_W   = $clog2(DEEP) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              clr,
    input logic              rewind,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  thresh,
    input logic              irq_pol,
    input logic [CNT_W-1:0]  fill,
    input logic              deep_mode,
    input logic              ovf,
    input logic              udf,
    input logic              irq_nempty,
    input logic              irq_thr,
    input logic              irq_full
);

    logic [CNT_W-1:0] lim;
    assign lim = deep_mode ? CNT_W'(DEEP) : CNT_W'(SHALLOW);

    assert_fill_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= lim);

    assert_nempty_pol_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nempty == ((fill != '0) ^ irq_pol));

    assert_full_pol_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_full == ((fill == lim) ^ irq_pol));

    assert_thr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_thr == ((fill >= thresh) ^ irq_pol));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !rewind && wr_en && !rd_en && fill == lim)
        |=> (fill == $past(fill) && ovf));

    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !rewind && rd_en && fill == '0)
        |=> (rd_data == '0 && udf));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fill == '0 && !ovf && !udf));

    assert_resize_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != '0) |=> $stable(deep_mode));

    assert_both_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !rewind && wr_en && rd_en && fill != '0 && fill < lim)
        |=> (fill == $past(fill)));

endmodule

bind txbuf_fifo txbuf_fifo_chk #(.DEEP(DEEP), .SHALLOW(SHALLOW), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/txbuf_fifo_test.sv
module txbuf_fifo_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, clr = 1'b0, rewind = 1'b0;
    logic       depth_sel = 1'b0, irq_pol = 1'b0;
    logic [7:0] wr_data = '0;
    logic [6:0] thresh = 7'd16;
    logic [7:0] rd_data;
    logic [6:0] fill;
    logic       deep_mode, ovf, udf, irq_nempty, irq_thr, irq_full;

    txbuf_fifo uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .clr(clr), .rewind(rewind),
        .depth_sel(depth_sel), .thresh(thresh), .irq_pol(irq_pol),
        .fill(fill), .deep_mode(deep_mode), .ovf(ovf), .udf(udf),
        .irq_nempty(irq_nempty), .irq_thr(irq_thr), .irq_full(irq_full)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  tests = 0, fails = 0;
    int  wlog [512];
    int  wn = 0, ri = 0, mdeep = 0, seq = 0;
    bit  mlost = 0, movf = 0, mudf = 0, done = 0;

    function automatic int mcap();
        return mdeep ? 64 : 32;
    endfunction

    function automatic int mfill();
        return wn - ri;
    endfunction

    function automatic int pat(int i);
        return (i * 29 + 7) & 255;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_status(string tag);
        int f;
        f = mfill();
        check({tag, " fill"}, int'(fill), f);
        check({tag, " nempty R9"}, int'(irq_nempty), int'(f > 0) ^ int'(irq_pol));
        check({tag, " full R9"}, int'(irq_full), int'(f == mcap()) ^ int'(irq_pol));
        check({tag, " thr R10"}, int'(irq_thr), int'(f >= int'(thresh)) ^ int'(irq_pol));
        check({tag, " ovf"}, int'(ovf), int'(movf));
        check({tag, " udf"}, int'(udf), int'(mudf));
    endtask

    task automatic model_push(int b);
        if (mfill() < mcap()) begin
            if (wn == mcap()) mlost = 1;
            wlog[wn] = b;
            wn++;
        end else movf = 1;
    endtask

    task automatic do_push(string tag);
        int b;
        b = pat(seq);
        seq++;
        wr_en = 1'b1; wr_data = 8'(b);
        tick();
        wr_en = 1'b0;
        model_push(b);
        check_status(tag);
    endtask

    task automatic do_pop(string tag);
        int e;
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        if (mfill() > 0) begin e = wlog[ri]; ri++; end
        else begin e = 0; mudf = 1; end
        check({tag, " data"}, int'(rd_data), e);
        check_status(tag);
    endtask

    task automatic do_both(string tag);
        int b, e, f;
        b = pat(seq);
        seq++;
        f = mfill();
        wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'(b);
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
        if (f > 0) begin e = wlog[ri]; ri++; end
        else begin e = 0; mudf = 1; end
        if (f < mcap()) begin
            if (wn == mcap()) mlost = 1;
            wlog[wn] = b; wn++;
        end else movf = 1;
        check({tag, " data"}, int'(rd_data), e);
        check_status(tag);
    endtask

    task automatic do_clear(string tag);
        clr = 1'b1;
        tick();
        clr = 1'b0;
        wn = 0; ri = 0; mlost = 0; movf = 0; mudf = 0;
        check_status(tag);
    endtask

    task automatic do_restore(string tag);
        rewind = 1'b1;
        tick();
        rewind = 1'b0;
        if (!mlost) ri = 0;
        check_status(tag);
    endtask

    task automatic set_depth(int d);
        depth_sel = d[0];
        tick();
        if (mfill() == 0 && d != mdeep) begin
            mdeep = d; wn = 0; ri = 0; mlost = 0;
        end
        check("R8 depth applied", int'(deep_mode), mdeep);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 fill", int'(fill), 0);
        check("R1 deep_mode", int'(deep_mode), 0);
        check("R1 ovf", int'(ovf), 0);
        check("R1 udf", int'(udf), 0);
        check("R1 rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        tick();
        check_status("R1 after release");

        // Fill, overflow, drain, underflow at both capacities
        for (int d = 0; d < 2; d++) begin
            set_depth(d);
            thresh = 7'(mcap() / 2);
            for (int i = 0; i < mcap(); i++) do_push("R2 fill");
            do_push("R3 push when full");
            tick();
            check("R2 rd_data held", int'(rd_data), 0);
            for (int i = 0; i < mcap(); i++) do_pop("R2 drain");
            do_pop("R4 pop when empty");
            do_clear("R5 clear flags");
        end

        // Rewind within the window
        set_depth(0);
        for (int i = 0; i < 10; i++) do_push("R6 load");
        for (int i = 0; i < 4; i++) do_pop("R6 partial read");
        do_restore("R6 rewind");
        check("R6 fill after rewind", int'(fill), 10);
        for (int i = 0; i < 10; i++) do_pop("R6 resend");
        do_restore("R6 second rewind");
        for (int i = 0; i < 10; i++) do_pop("R6 resend again");

        // Rewind after the first byte was overwritten
        do_clear("R7 clear");
        for (int i = 0; i < 32; i++) do_push("R7 load");
        do_pop("R7 pop one");
        do_push("R7 overwrite");
        do_pop("R7 pop two");
        do_restore("R7 rewind ignored");
        check("R7 fill unchanged", int'(fill), 31);
        while (mfill() > 0) do_pop("R7 drain");

        // Clear wins over a write in the same cycle
        do_push("R5 preload");
        wr_en = 1'b1; clr = 1'b1; wr_data = 8'h55;
        tick();
        wr_en = 1'b0; clr = 1'b0;
        wn = 0; ri = 0; mlost = 0; movf = 0; mudf = 0;
        check_status("R5 clear with write");

        // Resize request while holding data
        do_push("R8 preload");
        depth_sel = 1'b1;
        tick();
        check("R8 resize ignored", int'(deep_mode), 0);
        do_pop("R8 pop");
        check("R8 still shallow", int'(deep_mode), 0);
        tick();
        mdeep = 1; wn = 0; ri = 0; mlost = 0;
        check("R8 resize later", int'(deep_mode), 1);
        set_depth(0);

        // Threshold sweep at shallow capacity, both polarities
        for (int p = 0; p < 2; p++) begin
            irq_pol = p[0];
            do_clear("R11 clear");
            for (int f = 0; f <= 32; f++) begin
                for (int t = 0; t <= 33; t++) begin
                    thresh = 7'(t);
                    #1;
                    check("R10 R11 thr sweep", int'(irq_thr), int'(f >= t) ^ p);
                end
                check("R11 nempty", int'(irq_nempty), int'(f > 0) ^ p);
                check("R11 full", int'(irq_full), int'(f == 32) ^ p);
                if (f < 32) do_push("R10 step");
            end
        end
        irq_pol = 1'b0;
        thresh = 7'd8;

        // Simultaneous write and read at empty, middle, full
        do_clear("R12 clear");
        do_both("R12 both empty");
        for (int i = 0; i < 5; i++) do_push("R12 load");
        for (int i = 0; i < 6; i++) do_both("R12 both middle");
        while (mfill() < mcap()) do_push("R12 to full");
        do_both("R12 both full");
        while (mfill() > 0) do_pop("R12 drain");

        finish_run();
    end

endmodule